// File: doc/BRIEF.md
# Prioritized Interrupt Status Queue

This block gathers status reports from five event sources and hands them to a host one at a time through a single 16-bit read port. Each returned word carries a 6-bit source tag in its low bits and the source's 10-bit status contents above it. Reading a word consumes that report, and the next pending report takes its place. Once nothing is pending, a read returns zero.

The receive and transmit sources each own a small queue, so several of their reports can wait at once. The buffer, receive-miss and transmit-collision sources each hold at most one report, and later events from them fold into it. Reports leave in a fixed priority order.

An interrupt request line is raised while reports are pending and the global enable is set. The host's first read forces the request low. The request stays low until the host has read a zero word and a minimum number of clock cycles has passed, whichever comes later. A select input chooses which of several request lines carries the request, and a separate input disables every line's output enable.

Top module: `irq_status_queue`

## Requirements
- R1: A read word is {contents[9:0], tag[5:0]}: bits 5:0 hold the tag (receive 0x04, transmit 0x08, buffer 0x0C, receive-miss 0x10, transmit-collision 0x12) and bits 15:6 hold the 10-bit contents.
- R2: While reports from several sources are pending, reads return them in the order receive, transmit, buffer, receive-miss, transmit-collision.
- R3: The receive and transmit sources each queue up to QDEPTH (default 4) reports, which are returned oldest first.
- R4: A receive or transmit event that arrives while its queue is full, with no read of that queue in the same cycle, is ORed into the newest entry.
- R5: An event from the buffer, receive-miss or transmit-collision source that arrives while that source already has a report pending is ORed into the pending contents. Only one report from that source is then returned.
- R6: rd_data is 0x0000 whenever no report is pending, and a read at that time changes nothing.
- R7: The clock edge on which rd_stb is high removes the report shown on rd_data.
- R8: The request is high on the clock edge after reports are pending, provided irq_enable is set and no hold is active. It is low on the clock edge after irq_enable is low.
- R9: A read while the request is high drives the request low on that edge. It stays low for at least HOLD_CYC cycles after that read.
- R10: During the hold, the request stays low until a read has returned the zero word, even after HOLD_CYC cycles.
- R11: After the hold releases, the request rises again if reports are pending and irq_enable is set.
- R12: irq_oe[i] is high only when line_sel equals i and lines_off is low. irq_out[i] equals the request ANDed with irq_oe[i].
- R13: After reset, no report is pending, rd_data is zero and the request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_vld | input | 1 | Receive event strobe |
| rx_info | input | 10 | Receive event contents |
| tx_vld | input | 1 | Transmit event strobe |
| tx_info | input | 10 | Transmit event contents |
| buf_vld | input | 1 | Buffer event strobe |
| buf_info | input | 10 | Buffer event contents |
| miss_vld | input | 1 | Receive-miss overflow strobe |
| miss_info | input | 10 | Receive-miss report contents |
| coll_vld | input | 1 | Transmit-collision overflow strobe |
| coll_info | input | 10 | Transmit-collision report contents |
| irq_enable | input | 1 | Global interrupt enable |
| line_sel | input | 2 | Selects the active request line |
| lines_off | input | 1 | Disables every line's output enable |
| rd_stb | input | 1 | Host read strobe; consumes the front report |
| rd_data | output | 16 | Front report word, or zero when nothing is pending |
| irq_out | output | 4 | Request lines |
| irq_oe | output | 4 | Per-line output enables |

## Verification
The hardest situation to reach is the hold window. Its exit needs two separate conditions: a zero-word read and an elapsed cycle count. The stimulus therefore reads one report while a lower-priority report still waits, and idles well past HOLD_CYC to show that time alone does not release the line. In a second pass it reads everything, including the zero word, right after the first read. It then posts a fresh event so that the release edge itself decides when the request returns. A sweep over all 31 non-empty combinations of simultaneous source strobes covers the priority order and the tag format.

// File: rtl/isq_pkg.sv
package isq_pkg;

    localparam int NSRC   = 5;
    localparam int STAT_W = 10;
    localparam int TAG_W  = 6;
    localparam int WORD_W = STAT_W + TAG_W;

    typedef enum logic [2:0] {
        SRC_RX   = 3'd0,
        SRC_TX   = 3'd1,
        SRC_BUF  = 3'd2,
        SRC_MISS = 3'd3,
        SRC_COLL = 3'd4
    } src_e;

    typedef struct packed {
        logic              vld;
        logic [STAT_W-1:0] info;
    } report_t;

    function automatic logic [TAG_W-1:0] tag_of(input int idx);
        case (idx)
            0:       return 6'h04;
            1:       return 6'h08;
            2:       return 6'h0C;
            3:       return 6'h10;
            default: return 6'h12;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input logic [STAT_W-1:0] info,
                                                    input logic [TAG_W-1:0] tag);
        return {info, tag};
    endfunction

    function automatic logic multi_entry(input int idx);
        return (idx == int'(SRC_RX)) || (idx == int'(SRC_TX));
    endfunction

endpackage

// File: rtl/isq_evt_fifo.sv
module isq_evt_fifo
    import isq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [STAT_W-1:0] push_info,
    input  logic              pop,
    output report_t           head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [STAT_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wr_q, rd_q, newest;
    logic [CNT_W-1:0]  cnt_q;
    logic              is_full, is_empty, do_pop, do_push, do_merge;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign is_full  = (cnt_q == FULL);
    assign is_empty = (cnt_q == '0);
    assign do_pop   = pop && !is_empty;
    assign do_push  = push && (!is_full || do_pop);
    assign do_merge = push && is_full && !do_pop;
    assign newest   = (wr_q == '0) ? LAST : wr_q - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (do_pop) begin
                mem_q[rd_q] <= '0;
                rd_q        <= bump(rd_q);
            end
            if (do_push) begin
                mem_q[wr_q] <= push_info;
                wr_q        <= bump(wr_q);
            end
            if (do_merge) mem_q[newest] <= mem_q[newest] | push_info;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head.vld  = !is_empty;
    assign head.info = mem_q[rd_q];

endmodule

// File: rtl/isq_evt_slot.sv
module isq_evt_slot
    import isq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [STAT_W-1:0] push_info,
    input  logic              pop,
    output report_t           head
);
    report_t slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (push) begin
            slot_q.vld  <= 1'b1;
            slot_q.info <= (pop || !slot_q.vld) ? push_info : (slot_q.info | push_info);
        end else if (pop) begin
            slot_q <= '0;
        end
    end

    assign head = slot_q;

endmodule

// File: rtl/isq_front_sel.sv
module isq_front_sel
    import isq_pkg::*;
(
    input  report_t             heads [NSRC],
    input  logic                rd_stb,
    output logic [WORD_W-1:0]   word,
    output logic [NSRC-1:0]     pops,
    output logic                any
);
    logic [NSRC-1:0] grant;

    always_comb begin
        grant = '0;
        word  = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (heads[i].vld) begin
                grant = '0;
                grant[i] = 1'b1;
                word = pack_word(heads[i].info, tag_of(i));
            end
        end
    end

    assign any  = |grant;
    assign pops = rd_stb ? grant : '0;

endmodule

// File: rtl/isq_irq_ctrl.sv
module isq_irq_ctrl #(
    parameter int HOLD_CYC = 80,
    parameter int LINES    = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     enable,
    input  logic                     pending,
    input  logic                     rd_stb,
    input  logic [$clog2(LINES)-1:0] line_sel,
    input  logic                     lines_off,
    output logic                     req,
    output logic [LINES-1:0]         lines,
    output logic [LINES-1:0]         lines_oe
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_CYC - 1);
    localparam int SEL_W = $clog2(LINES);

    logic             req_q, holding_q, null_seen_q;
    logic [CNT_W-1:0] cnt_q;
    logic             null_now, hold_done;

    assign null_now  = rd_stb && !pending;
    assign hold_done = (null_seen_q || null_now) && (cnt_q >= LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q       <= 1'b0;
            holding_q   <= 1'b0;
            null_seen_q <= 1'b0;
            cnt_q       <= '0;
        end else if (holding_q) begin
            req_q <= 1'b0;
            if (hold_done) begin
                holding_q   <= 1'b0;
                null_seen_q <= 1'b0;
            end else begin
                null_seen_q <= null_seen_q || null_now;
                if (cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
            end
        end else if (rd_stb && req_q) begin
            req_q       <= 1'b0;
            holding_q   <= 1'b1;
            null_seen_q <= null_now;
            cnt_q       <= '0;
        end else begin
            req_q <= enable && pending;
        end
    end

    assign req = req_q;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign lines_oe[i] = !lines_off && (line_sel == SEL_W'(i));
        assign lines[i]    = lines_oe[i] && req_q;
    end

endmodule

// File: rtl/irq_status_queue.sv
module irq_status_queue
    import isq_pkg::*;
#(
    parameter int QDEPTH   = 4,
    parameter int HOLD_CYC = 80,
    parameter int LINES    = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rx_vld,
    input  logic [9:0]               rx_info,
    input  logic                     tx_vld,
    input  logic [9:0]               tx_info,
    input  logic                     buf_vld,
    input  logic [9:0]               buf_info,
    input  logic                     miss_vld,
    input  logic [9:0]               miss_info,
    input  logic                     coll_vld,
    input  logic [9:0]               coll_info,
    input  logic                     irq_enable,
    input  logic [$clog2(LINES)-1:0] line_sel,
    input  logic                     lines_off,
    input  logic                     rd_stb,
    output logic [15:0]              rd_data,
    output logic [LINES-1:0]         irq_out,
    output logic [LINES-1:0]         irq_oe
);
    logic [NSRC-1:0]   evt_vld;
    logic [STAT_W-1:0] evt_info [NSRC];
    report_t           heads    [NSRC];
    logic [NSRC-1:0]   pops;
    logic              any_pending;
    logic              irq_req;

    assign evt_vld     = {coll_vld, miss_vld, buf_vld, tx_vld, rx_vld};
    assign evt_info[0] = rx_info;
    assign evt_info[1] = tx_info;
    assign evt_info[2] = buf_info;
    assign evt_info[3] = miss_info;
    assign evt_info[4] = coll_info;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        if (multi_entry(s)) begin : g_queue
            isq_evt_fifo #(.DEPTH(QDEPTH)) u_fifo (
                .clk(clk), .rst(rst),
                .push(evt_vld[s]), .push_info(evt_info[s]),
                .pop(pops[s]), .head(heads[s])
            );
        end else begin : g_single
            isq_evt_slot u_slot (
                .clk(clk), .rst(rst),
                .push(evt_vld[s]), .push_info(evt_info[s]),
                .pop(pops[s]), .head(heads[s])
            );
        end
    end

    isq_front_sel u_sel (
        .heads(heads), .rd_stb(rd_stb),
        .word(rd_data), .pops(pops), .any(any_pending)
    );

    isq_irq_ctrl #(.HOLD_CYC(HOLD_CYC), .LINES(LINES)) u_irq (
        .clk(clk), .rst(rst),
        .enable(irq_enable), .pending(any_pending), .rd_stb(rd_stb),
        .line_sel(line_sel), .lines_off(lines_off),
        .req(irq_req), .lines(irq_out), .lines_oe(irq_oe)
    );

endmodule

// File: rtl/isq_checker.sv
module isq_checker #(
    parameter int LINES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             irq_enable,
    input logic             rd_stb,
    input logic             pending,
    input logic             req,
    input logic [15:0]      rd_data,
    input logic [LINES-1:0] irq_out,
    input logic [LINES-1:0] irq_oe
);
    // R12
    oe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_oe));

    // R12
    single_line_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(irq_out) <= 1);

    // R6
    null_word_chk: assert property (@(posedge clk) disable iff (rst)
        !pending |-> (rd_data == 16'h0000));

    // R1
    tag_legal_chk: assert property (@(posedge clk) disable iff (rst)
        pending |-> (rd_data[5:0] inside {6'h04, 6'h08, 6'h0C, 6'h10, 6'h12}));

    // R8
    enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_enable |=> !req);

    // R9
    first_read_low_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && req) |=> !req);

endmodule

bind irq_status_queue isq_checker #(.LINES(LINES)) u_isq_chk (
    .clk(clk), .rst(rst), .irq_enable(irq_enable), .rd_stb(rd_stb),
    .pending(any_pending), .req(irq_req), .rd_data(rd_data),
    .irq_out(irq_out), .irq_oe(irq_oe)
);

// File: tb/irq_status_queue_test.sv
`timescale 1ns/1ps
module irq_status_queue_test;
    localparam int HOLD = 80;
    localparam int QD   = 4;

    logic        clk = 0;
    logic        rst = 1;
    logic [4:0]  vld = '0;
    logic [9:0]  info [5];
    logic        irq_enable = 0;
    logic [1:0]  line_sel = '0;
    logic        lines_off = 0;
    logic        rd_stb = 0;
    logic [15:0] rd_data;
    logic [3:0]  irq_out, irq_oe;

    int checks = 0;
    int errors = 0;

    localparam logic [5:0] TAGS [5] = '{6'h04, 6'h08, 6'h0C, 6'h10, 6'h12};

    always #4 clk = ~clk;

    irq_status_queue #(.QDEPTH(QD), .HOLD_CYC(HOLD), .LINES(4)) uut (
        .clk(clk), .rst(rst),
        .rx_vld(vld[0]),   .rx_info(info[0]),
        .tx_vld(vld[1]),   .tx_info(info[1]),
        .buf_vld(vld[2]),  .buf_info(info[2]),
        .miss_vld(vld[3]), .miss_info(info[3]),
        .coll_vld(vld[4]), .coll_info(info[4]),
        .irq_enable(irq_enable), .line_sel(line_sel), .lines_off(lines_off),
        .rd_stb(rd_stb), .rd_data(rd_data), .irq_out(irq_out), .irq_oe(irq_oe)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1; vld = '0; rd_stb = 0;
        repeat (2) tick();
        rst = 0;
    endtask

    task automatic post(input int s, input logic [9:0] d);
        vld[s] = 1'b1; info[s] = d;
        tick();
        vld = '0;
    endtask

    task automatic read_chk(input logic [15:0] exp, input string req);
        check(rd_data, exp, req);
        rd_stb = 1;
        tick();
        rd_stb = 0;
    endtask

    initial begin
        for (int i = 0; i < 5; i++) info[i] = '0;
        do_reset();
        // R13 reset state
        check(rd_data, 16'h0000, "R13");
        check({12'h0, irq_out}, 16'h0, "R13");
        check({12'h0, irq_oe}, 16'h1, "R12");

        // R2 / R1 / R7 sweep of all simultaneous source combinations
        for (int m = 1; m < 32; m++) begin
            logic [9:0] dv [5];
            for (int s = 0; s < 5; s++) begin
                dv[s] = 10'((m * 7 + s * 37) | 1);
                info[s] = dv[s];
                vld[s] = m[s];
            end
            tick();
            vld = '0;
            for (int s = 0; s < 5; s++)
                if (m[s]) read_chk({dv[s], TAGS[s]}, "R2");
            // R6 null read
            read_chk(16'h0000, "R6");
        end

        // R3 FIFO order for receive and transmit
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < QD; k++) post(s, 10'(16 * s + k + 3));
            for (int k = 0; k < QD; k++) read_chk({10'(16 * s + k + 3), TAGS[s]}, "R3");
            read_chk(16'h0000, "R7");
        end

        // R4 merge into newest entry when full
        for (int k = 0; k < QD; k++) post(0, 10'(1 << k));
        post(0, 10'h100);
        post(0, 10'h200);
        for (int k = 0; k < QD - 1; k++) read_chk({10'(1 << k), 6'h04}, "R4");
        read_chk({10'((1 << (QD - 1)) | 10'h300), 6'h04}, "R4");
        read_chk(16'h0000, "R4");

        // R5 single-entry merge for each single-slot source
        for (int s = 2; s < 5; s++) begin
            post(s, 10'h001);
            post(s, 10'h050);
            read_chk({10'h051, TAGS[s]}, "R5");
            read_chk(16'h0000, "R5");
        end

        // Interrupt behaviour
        do_reset();
        post(0, 10'h055);
        repeat (3) tick();
        check({12'h0, irq_out}, 16'h0, "R8");
        irq_enable = 1;
        tick();
        check({12'h0, irq_out}, 16'h1, "R8");
        post(1, 10'h0AA);
        read_chk({10'h055, 6'h04}, "R1");
        check({12'h0, irq_out}, 16'h0, "R9");
        repeat (HOLD + 10) tick();
        check({12'h0, irq_out}, 16'h0, "R10");
        read_chk({10'h0AA, 6'h08}, "R1");
        read_chk(16'h0000, "R6");
        post(0, 10'h101);
        tick();
        check({12'h0, irq_out}, 16'h1, "R11");

        // minimum hold after null read comes early
        read_chk({10'h101, 6'h04}, "R7");
        read_chk(16'h0000, "R6");
        post(2, 10'h003);
        repeat (HOLD - 3) tick();
        check({12'h0, irq_out}, 16'h0, "R9");
        repeat (3) tick();
        check({12'h0, irq_out}, 16'h1, "R11");

        // R12 line select and disable sweep
        for (int off = 0; off < 2; off++) begin
            for (int s = 0; s < 4; s++) begin
                logic [3:0] eo;
                line_sel = 2'(s); lines_off = off[0];
                #1;
                eo = off[0] ? 4'b0 : 4'(1 << s);
                check({12'h0, irq_oe}, {12'h0, eo}, "R12");
                check({12'h0, irq_out}, {12'h0, eo}, "R12");
            end
        end
        line_sel = 0; lines_off = 0;

        irq_enable = 0;
        tick();
        check({12'h0, irq_out}, 16'h0, "R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule